// File: doc/BRIEF.md
# Dynamic phase alignment controller

This block chooses a sampling phase for one serial receive lane. Every reference clock cycle it receives one sample of the same serial data from each of eight sampling-clock phases spaced an eighth of a bit apart. It learns where the data edges fall among those phases and steers a 3-bit phase select toward the phase lying farthest from the edges. Once enough training evidence has been gathered at a settled phase, it raises a lock flag. The analog phase generation and the deserializer that consume the select are outside this block.

Observation is split into fixed windows of `WIN_LEN` cycles. Within a window, each phase notes whether its sample ever differed from either circular neighbour. At the end of each window that saw at least one such difference, the controller either moves the phase one step toward the best candidate or credits one training repetition. A hold input stops all phase movement. A synchronous reset discards the lock and the training history.

Top module: `dpa_ctrl`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `phase_sel` is 0, `locked` is 0 and `lock_pulse` is 0.
- R2: `locked` rises only after `TRAIN_REPS` (default 256) qualifying windows have been evaluated with no phase move since reset or since the last move. It stays low after `TRAIN_REPS`-1 such windows.
- R3: A window is qualifying only if at least one phase disagreed with a neighbour in some cycle of it. A window in which all samples match neither moves the phase nor counts toward training.
- R4: While `hold` is high at a window evaluation, `phase_sel` does not change. Qualifying windows still count toward training, and an existing lock is kept.
- R5: After lock, any phase move clears `locked` in the same cycle as the move. Each move is to an adjacent phase, so this rule also covers two moves in the same direction.
- R6: A phase move is at most one step per window, toward the target along the shorter way round, with 7 wrapping to 0 and 0 to 7. When the target is exactly four steps away, the step is upward (+1).
- R7: A reset while locked clears the lock and the training count. Lock then again needs `TRAIN_REPS` fresh qualifying windows.
- R8: `samp[p]` is the sample of phase p. Phase p is flagged for a window if, in any cycle of that window, `samp[p]` differs from `samp[p-1]` or from `samp[p+1]` (indices taken mod 8). The score of phase p is the number of flagged phases among p-1, p and p+1. The target is the phase with the lowest score, and a tie goes to the lowest index.
- R9: `lock_pulse` is high for exactly one cycle, the cycle in which `locked` first rises after a reset. A relock after a move produces no pulse.
- R10: Windows are `WIN_LEN` (default 4) cycles long. The first window starts in the first cycle after `rst` falls, and windows follow back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset; forces retraining |
| hold | input | 1 | Freezes the selected phase while high |
| samp | input | 8 | One data sample per phase, bit p from phase p |
| phase_sel | output | 3 | Selected sampling phase |
| locked | output | 1 | Lock flag |
| lock_pulse | output | 1 | One-cycle mark of the first lock after reset |

## Verification
Two functions can meet in one evaluation cycle: a window whose winner differs from the current phase asks for a move, while `hold` blocks it and the same window also earns a training credit. The bench provokes this by locking at phase 0 and then feeding windows whose best phase is 2 with `hold` high across every evaluation. It judges the result by requiring that `phase_sel` stays 0 and `locked` stays high. Releasing `hold` must then produce a single step to phase 1 with the lock dropped in that same cycle.

// File: rtl/dpa_pkg.sv
package dpa_pkg;
  typedef enum logic [1:0] {
    MV_NONE = 2'd0,
    MV_UP   = 2'd1,
    MV_DN   = 2'd2
  } move_e;
endpackage

// File: rtl/dpa_edge_window.sv
// Collects, per phase, whether it disagreed with a circular neighbour
// during a window of WIN_LEN cycles; presents the result one cycle later.
module dpa_edge_window #(
  parameter int NPH     = 8,
  parameter int WIN_LEN = 4,
  localparam int WCW    = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NPH-1:0] samp,
  output logic [NPH-1:0] win_flags,
  output logic           win_done
);
  logic [NPH-1:0] cur;
  logic [NPH-1:0] acc;
  logic [WCW-1:0] wcnt;
  logic           last;

  for (genvar p = 0; p < NPH; p++) begin : g_diff
    localparam int UP = (p + 1) % NPH;
    localparam int DN = (p + NPH - 1) % NPH;
    assign cur[p] = (samp[p] ^ samp[UP]) | (samp[p] ^ samp[DN]);
  end

  assign last = (wcnt == WCW'(WIN_LEN - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      wcnt      <= '0;
      acc       <= '0;
      win_flags <= '0;
      win_done  <= 1'b0;
    end else begin
      win_done <= last;
      if (last) begin
        win_flags <= acc | cur;
        acc       <= '0;
        wcnt      <= '0;
      end else begin
        acc  <= acc | cur;
        wcnt <= wcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dpa_phase_pick.sv
// Scores each phase by flagged phases in its neighbourhood; lowest wins,
// ties to the lower index.
module dpa_phase_pick #(
  parameter int NPH = 8,
  localparam int PW = $clog2(NPH)
) (
  input  logic [NPH-1:0] flags,
  output logic [PW-1:0]  target,
  output logic           valid
);
  logic [1:0] score [NPH];

  for (genvar p = 0; p < NPH; p++) begin : g_score
    localparam int UP = (p + 1) % NPH;
    localparam int DN = (p + NPH - 1) % NPH;
    assign score[p] = {1'b0, flags[DN]} + {1'b0, flags[p]} + {1'b0, flags[UP]};
  end

  always_comb begin
    logic [1:0] best;
    best   = score[0];
    target = '0;
    for (int p = 1; p < NPH; p++) begin
      if (score[p] < best) begin
        best   = score[p];
        target = PW'(p);
      end
    end
  end

  assign valid = |flags;
endmodule

// File: rtl/dpa_track.sv
// Steps the phase toward the target, counts training windows and
// manages the lock flag and the first-lock pulse.
module dpa_track
  import dpa_pkg::*;
#(
  parameter int NPH        = 8,
  parameter int TRAIN_REPS = 256,
  localparam int PW        = $clog2(NPH),
  localparam int CW        = $clog2(TRAIN_REPS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hold,
  input  logic          eval,
  input  logic          valid,
  input  logic [PW-1:0] target,
  output logic [PW-1:0] phase_sel,
  output logic          locked,
  output logic          lock_pulse
);
  logic [PW-1:0] diff;
  move_e         mv;
  logic [CW-1:0] cnt;
  logic [CW:0]   cnt_inc;
  logic          reach;
  logic          seen;

  assign diff    = target - phase_sel;
  assign cnt_inc = {1'b0, cnt} + 1'b1;
  assign reach   = (cnt_inc >= (CW+1)'(TRAIN_REPS));

  always_comb begin
    if (diff == '0)                          mv = MV_NONE;
    else if (diff <= PW'(NPH / 2))           mv = MV_UP;
    else                                     mv = MV_DN;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_sel  <= '0;
      cnt        <= '0;
      locked     <= 1'b0;
      lock_pulse <= 1'b0;
      seen       <= 1'b0;
    end else begin
      lock_pulse <= 1'b0;
      if (eval && valid) begin
        if (!hold && mv != MV_NONE) begin
          phase_sel <= (mv == MV_UP) ? phase_sel + 1'b1 : phase_sel - 1'b1;
          cnt       <= '0;
          locked    <= 1'b0;
        end else begin
          if (cnt != CW'(TRAIN_REPS)) cnt <= cnt_inc[CW-1:0];
          if (!locked && reach) begin
            locked <= 1'b1;
            if (!seen) begin
              lock_pulse <= 1'b1;
              seen       <= 1'b1;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/dpa_ctrl.sv
module dpa_ctrl #(
  parameter int NPH        = 8,
  parameter int WIN_LEN    = 4,
  parameter int TRAIN_REPS = 256,
  localparam int PW        = $clog2(NPH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           hold,
  input  logic [NPH-1:0] samp,
  output logic [PW-1:0]  phase_sel,
  output logic           locked,
  output logic           lock_pulse
);
  logic [NPH-1:0] win_flags;
  logic           win_done;
  logic [PW-1:0]  target;
  logic           valid;

  dpa_edge_window #(.NPH(NPH), .WIN_LEN(WIN_LEN)) u_win (
    .clk(clk), .rst(rst), .samp(samp),
    .win_flags(win_flags), .win_done(win_done)
  );

  dpa_phase_pick #(.NPH(NPH)) u_pick (
    .flags(win_flags), .target(target), .valid(valid)
  );

  dpa_track #(.NPH(NPH), .TRAIN_REPS(TRAIN_REPS)) u_track (
    .clk(clk), .rst(rst), .hold(hold), .eval(win_done), .valid(valid),
    .target(target), .phase_sel(phase_sel), .locked(locked),
    .lock_pulse(lock_pulse)
  );
endmodule

// File: rtl/dpa_ctrl_chk.sv
module dpa_ctrl_chk #(
  parameter int PW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          hold,
  input logic [PW-1:0] phase_sel,
  input logic          locked,
  input logic          lock_pulse
);
  assert_reset_state_R1: assert property (@(posedge clk)
    $past(rst) |-> (!locked && !lock_pulse && phase_sel == '0));

  assert_hold_freeze_R4: assert property (@(posedge clk) disable iff (rst)
    hold |=> $stable(phase_sel));

  assert_move_unlocks_R5: assert property (@(posedge clk) disable iff (rst)
    (phase_sel != $past(phase_sel)) |-> !locked);

  assert_single_step_R6: assert property (@(posedge clk) disable iff (rst)
    (phase_sel != $past(phase_sel)) |->
      ((PW'(phase_sel - $past(phase_sel)) == PW'(1)) ||
       (PW'($past(phase_sel) - phase_sel) == PW'(1))));

  assert_pulse_on_rise_R9: assert property (@(posedge clk) disable iff (rst)
    lock_pulse |-> (locked && !$past(locked)));
endmodule

bind dpa_ctrl dpa_ctrl_chk #(.PW(PW)) u_chk (
  .clk(clk), .rst(rst), .hold(hold), .phase_sel(phase_sel),
  .locked(locked), .lock_pulse(lock_pulse)
);

// File: tb/test_dpa_ctrl.sv
module test_dpa_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int WIN_LEN    = 4;
  localparam int TRAIN      = 256;
  // patterns: bit p = phase p sample
  localparam logic [7:0] PAT_W0 = 8'b0011_1100; // best phase 0
  localparam logic [7:0] PAT_W2 = 8'b1110_0000; // best phase 2
  localparam logic [7:0] PAT_W6 = 8'b0000_1110; // best phase 6
  localparam logic [7:0] PAT_W1 = 8'b0111_0000; // best phase 1
  localparam logic [7:0] PAT_W5 = 8'b0000_0111; // best phase 5

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       hold = 1'b0;
  logic [7:0] samp = 8'h00;
  logic [2:0] phase_sel;
  logic       locked;
  logic       lock_pulse;
  int checks = 0;
  int errors = 0;
  int npulse = 0;

  dpa_ctrl #(.NPH(8), .WIN_LEN(WIN_LEN), .TRAIN_REPS(TRAIN)) i_dpa_ctrl (
    .clk(clk), .rst(rst), .hold(hold), .samp(samp),
    .phase_sel(phase_sel), .locked(locked), .lock_pulse(lock_pulse)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) if (!rst && lock_pulse) npulse++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic feed(input logic [7:0] pat, input int nwin);
    for (int i = 0; i < nwin * WIN_LEN; i++) begin
      samp = pat;
      @(negedge clk);
    end
  endtask

  task automatic idle();
    feed(8'h00, 1);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    samp = 8'h00;
    repeat (2) @(negedge clk);
    chk("R1 locked in reset", locked, 0);
    chk("R1 phase in reset", phase_sel, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 locked after reset", locked, 0);
    chk("R1 pulse after reset", lock_pulse, 0);
    // first window began in the cycle just consumed: pad it with idle samples
    feed(8'h00, 0);
    for (int i = 1; i < WIN_LEN; i++) @(negedge clk);
  endtask

  task automatic t_train(input int exp_pulses);
    feed(PAT_W0, TRAIN - 1);
    feed(8'h00, 3);
    chk("R2 not locked after one short", locked, 0);
    chk("R3 quiet windows do not count", locked, 0);
    chk("R8 phase stays at best 0", phase_sel, 0);
    feed(PAT_W0, 1);
    idle();
    chk("R2 locked after full training", locked, 1);
    chk("R9 pulse count", npulse, exp_pulses);
  endtask

  task automatic t_hold();
    hold = 1'b1;
    feed(PAT_W2, 3);
    idle();
    chk("R4 phase frozen by hold", phase_sel, 0);
    chk("R4 lock kept under hold", locked, 1);
    hold = 1'b0;
  endtask

  task automatic t_move();
    feed(PAT_W2, 1);
    idle();
    chk("R6 one step toward 2", phase_sel, 1);
    chk("R5 move clears lock", locked, 0);
    feed(PAT_W2, 1);
    idle();
    chk("R8 reached best 2", phase_sel, 2);
    feed(PAT_W2, 1);
    idle();
    chk("R6 no move at target", phase_sel, 2);
  endtask

  task automatic t_relock();
    feed(PAT_W2, TRAIN);
    idle();
    chk("R2 relock after move", locked, 1);
    chk("R9 no pulse on relock", npulse, 1);
  endtask

  task automatic t_wrap();
    feed(PAT_W6, 1); idle();
    chk("R6 down wrap 0 to 7", phase_sel, 7);
    feed(PAT_W6, 1); idle();
    chk("R6 reached 6", phase_sel, 6);
    feed(PAT_W1, 1); idle();
    chk("R6 up step 6 to 7", phase_sel, 7);
    feed(PAT_W1, 1); idle();
    chk("R6 up wrap 7 to 0", phase_sel, 0);
    feed(PAT_W1, 1); idle();
    chk("R6 reached 1", phase_sel, 1);
    feed(PAT_W5, 1); idle();
    chk("R6 tie of four goes up", phase_sel, 2);
  endtask

  initial begin
    do_reset();
    t_train(1);
    t_hold();
    t_move();
    t_relock();
    // R7: reset while locked discards lock and history
    do_reset();
    chk("R7 lock cleared by reset", locked, 0);
    t_train(2);
    chk("R10 window count aligned to reset", phase_sel, 0);
    t_wrap();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule